// File: doc/BRIEF.md
# Synchronous Serial Bit-Clock Edge Interface

This block serves a serial port that runs in clocked (synchronous) mode. It turns the serial bit clock into two single-cycle strobes in the system clock domain. One strobe, `tx_change`, marks the moment the transmit line may move. The other, `rx_sample`, marks the moment the receive line is captured. A polarity input chooses which bit-clock edge plays which role. The two roles always sit on opposite edges.

In slave mode the bit clock arrives on `sclk_in` from outside. The pin is never used as a clock. It passes through two system-clock flops and an edge detector, so every strobe appears a fixed two system cycles after the pin moves. For that reason the external clock must stay below a quarter of the system clock rate. In master mode the block makes the bit clock itself with an even divider and drives it on `sclk_out` with `sclk_oe` high. In this mode the strobes come from the divider's own toggle events.

A small frame engine shows how the strobes are used. It sends a byte least significant bit first on `txd`, shifts the bits on `rxd` in, and pulses `frame_done` when the byte is complete.

Top module: `sync_bitclk_if`

## Requirements
- R1: In slave mode a transition on `sclk_in` that is first captured at system edge k produces exactly one strobe. The strobe is high for the single cycle after edge k+1 and low in the cycle after edge k. This is a fixed latency of two system cycles.
- R2: With `clk_pol`=0 a rising bit-clock edge gives `tx_change` and a falling edge gives `rx_sample`. With `clk_pol`=1 a falling edge gives `tx_change` and a rising edge gives `rx_sample`.
- R3: `tx_change` and `rx_sample` are never high in the same cycle.
- R4: When the block is idle, a `tx_start` pulse loads `tx_byte` and puts bit 0 on `txd` in the next cycle. The first `tx_change` of a frame comes before any sample and leaves `txd` alone. Each later `tx_change` presents the next bit. `txd` sits at 1 when idle.
- R5: Each `rx_sample` during a frame shifts `rxd` in from the top, so bits arrive least significant first. The cycle after the 8th sample, `rx_byte` holds the word and `frame_done` is high for one cycle.
- R6: In master mode `sclk_oe` is 1. During a frame `sclk_out` toggles every BIT_DIV/2 system cycles, and the matching strobe is high in the same cycle as each toggle. Between frames `sclk_out` rests at the level of `clk_pol`, and one frame gives 16 toggles.
- R7: While `rst` is high, `txd`=1, `rx_byte`=0, `frame_done`=0, both strobes are 0 and `sclk_out` equals `clk_pol`.
- R8: A `tx_start` that arrives while a frame is in progress is ignored. The byte that was sent and received is still the one loaded first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1 = generate the bit clock, 0 = accept it on `sclk_in` |
| clk_pol | input | 1 | Chooses which bit-clock edge changes data and which samples it |
| sclk_in | input | 1 | External bit clock (slave mode) |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| sclk_oe | output | 1 | Output enable for the bit-clock pin |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| tx_start | input | 1 | Starts a frame with `tx_byte` when idle |
| tx_byte | input | FRAME_W | Word to transmit |
| rx_byte | output | FRAME_W | Last completely received word |
| frame_done | output | 1 | One-cycle pulse after the final sample of a frame |
| tx_change | output | 1 | Transmit-change strobe |
| rx_sample | output | 1 | Receive-sample strobe |

## Verification
The latency property assumes that `sclk_in` holds each level for at least two system cycles, so that no pin edge is lost between synchronizer stages. The stimulus toggles the pin every three cycles, which is one sixth of the system rate and safely under the quarter-rate limit. The frame properties also assume that `clk_pol` and `master_en` stay constant while a frame is running. Each directed scenario sets both inputs before it starts a frame and changes neither until `frame_done`.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  // pair of one-cycle strobes produced by either clock source
  typedef struct packed {
    logic chg;
    logic smp;
  } edge_strobe_t;

  // map a detected bit-clock rise/fall to change/sample roles
  function automatic edge_strobe_t map_edge(input logic pol, input logic rise, input logic fall);
    edge_strobe_t s;
    s.chg = pol ? fall : rise;
    s.smp = pol ? rise : fall;
    return s;
  endfunction
endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync
  import bitclk_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         pol,
  input  logic         pin,
  output edge_strobe_t stb_o
);
  logic meta_q, hist_q;
  edge_strobe_t stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      hist_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      meta_q <= pin;
      hist_q <= meta_q;
      stb_q  <= map_edge(pol, meta_q & ~hist_q, hist_q & ~meta_q);
    end
  end

  assign stb_o = stb_q;

  // cycles since reset, saturating, so $past depth 3 stays after reset
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: a pin change captured at edge k yields a strobe after edge k+1
  p_edge_latency_r1: assert property (@(posedge clk) disable iff (rst)
    ((age_q == 2'd3) && ($past(pin, 2) != $past(pin, 3))) |-> (stb_q.chg || stb_q.smp));
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import bitclk_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pol,
  input  logic         run,
  output logic         sclk_o,
  output edge_strobe_t stb_o
);
  localparam int CNT_W = $clog2(HALF + 1);
  localparam logic [CNT_W-1:0] TURN = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  edge_strobe_t     stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= pol;
      stb_q  <= '0;
    end else begin
      stb_q <= '0;
      if (!run) begin
        cnt_q  <= '0;
        sclk_q <= pol;
      end else if (cnt_q == TURN) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
        stb_q  <= map_edge(pol, ~sclk_q, sclk_q);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign stb_o  = stb_q;

  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  // R6: every toggle during a frame carries its strobe in the same cycle
  p_toggle_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(run) && (sclk_q != $past(sclk_q))) |-> (stb_q.chg || stb_q.smp));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chg_i,
  input  logic               smp_i,
  input  logic               tx_start,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               rxd,
  output logic               txd,
  output logic [FRAME_W-1:0] rx_byte,
  output logic               done,
  output logic               busy
);
  localparam int BC_W = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] tx_sh, rx_sh, rx_q;
  logic [BC_W-1:0]    bit_cnt;
  logic               busy_q, txd_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
      bit_cnt <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (tx_start) begin
          busy_q  <= 1'b1;
          tx_sh   <= tx_byte;
          txd_q   <= tx_byte[0];
          bit_cnt <= '0;
        end
      end else if (smp_i) begin
        rx_sh <= {rxd, rx_sh[FRAME_W-1:1]};
        if (bit_cnt == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= {rxd, rx_sh[FRAME_W-1:1]};
          txd_q  <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (chg_i && bit_cnt != '0) begin
        txd_q <= tx_sh[1];
        tx_sh <= tx_sh >> 1;
      end
    end
  end

  assign txd     = txd_q;
  assign rx_byte = rx_q;
  assign done    = done_q;
  assign busy    = busy_q;

  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  // R5: completion follows a sample strobe by one cycle
  p_done_after_sample_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q && done_q) |-> $past(smp_i));

  // R4: the line moves only after a strobe or a start request
  p_txd_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(chg_i) && !$past(smp_i) && !$past(tx_start)) |-> $stable(txd_q));
endmodule

// File: rtl/sync_bitclk_if.sv
module sync_bitclk_if
  import bitclk_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int BIT_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master_en,
  input  logic               clk_pol,
  input  logic               sclk_in,
  output logic               sclk_out,
  output logic               sclk_oe,
  input  logic               rxd,
  output logic               txd,
  input  logic               tx_start,
  input  logic [FRAME_W-1:0] tx_byte,
  output logic [FRAME_W-1:0] rx_byte,
  output logic               frame_done,
  output logic               tx_change,
  output logic               rx_sample
);
  localparam int HALF = (BIT_DIV < 4) ? 2 : BIT_DIV / 2;

  edge_strobe_t slv_stb, mst_stb, use_stb;
  logic         busy;

  sclk_edge_sync u_edge (
    .clk   (clk),
    .rst   (rst),
    .pol   (clk_pol),
    .pin   (sclk_in),
    .stb_o (slv_stb)
  );

  sclk_divider #(.HALF(HALF)) u_div (
    .clk    (clk),
    .rst    (rst),
    .pol    (clk_pol),
    .run    (master_en & busy),
    .sclk_o (sclk_out),
    .stb_o  (mst_stb)
  );

  assign use_stb = master_en ? mst_stb : slv_stb;

  frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .chg_i    (use_stb.chg),
    .smp_i    (use_stb.smp),
    .tx_start (tx_start),
    .tx_byte  (tx_byte),
    .rxd      (rxd),
    .txd      (txd),
    .rx_byte  (rx_byte),
    .done     (frame_done),
    .busy     (busy)
  );

  assign sclk_oe   = master_en;
  assign tx_change = use_stb.chg;
  assign rx_sample = use_stb.smp;

  // R3: the two roles never coincide
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_change, rx_sample}));
endmodule

// File: tb/sync_bitclk_if_bench.sv
module sync_bitclk_if_bench;
  localparam int FRAME_W = 8;
  localparam int BIT_DIV = 4;
  localparam int HALF    = BIT_DIV / 2;

  logic clk = 1'b0;
  logic rst, master_en, clk_pol, sclk_in, tx_start;
  logic [FRAME_W-1:0] tx_byte;
  logic sclk_out, sclk_oe, txd, frame_done, tx_change, rx_sample;
  logic [FRAME_W-1:0] rx_byte;
  logic rxd;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign rxd = txd;

  sync_bitclk_if #(.FRAME_W(FRAME_W), .BIT_DIV(BIT_DIV)) u_sync_bitclk_if (
    .clk(clk), .rst(rst), .master_en(master_en), .clk_pol(clk_pol),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .rxd(rxd), .txd(txd), .tx_start(tx_start), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .frame_done(frame_done),
    .tx_change(tx_change), .rx_sample(rx_sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_reset(input logic pol);
    rst = 1'b1; master_en = 1'b0; clk_pol = pol; sclk_in = pol;
    tx_start = 1'b0; tx_byte = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(txd == 1'b1, "R7 txd", int'(txd), 1);
    chk(rx_byte == '0, "R7 rx_byte", int'(rx_byte), 0);
    chk(frame_done == 1'b0, "R7 frame_done", int'(frame_done), 0);
    chk({tx_change, rx_sample} == 2'b00, "R7 strobes", int'({tx_change, rx_sample}), 0);
    chk(sclk_out == pol, "R7 sclk_out", int'(sclk_out), int'(pol));
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // slave frame, pin toggled every 3 system cycles (fosc/6)
  task automatic slave_frame(input logic pol, input logic [FRAME_W-1:0] b, input bit inject);
    logic rise, exp_chg;
    master_en = 1'b0; clk_pol = pol; sclk_in = pol;
    repeat (4) @(negedge clk);
    tx_start = 1'b1; tx_byte = b;
    @(negedge clk);
    tx_start = 1'b0;
    // R4: bit 0 presented right after load
    chk(txd == b[0], "R4 first bit", int'(txd), int'(b[0]));
    if (inject) begin
      tx_start = 1'b1; tx_byte = ~b;
      @(negedge clk);
      tx_start = 1'b0;
    end
    for (int e = 0; e < 2 * FRAME_W; e++) begin
      sclk_in = ~sclk_in;
      rise = sclk_in;
      exp_chg = pol ? ~rise : rise;
      @(negedge clk);
      // R1: nothing one cycle after capture
      chk({tx_change, rx_sample} == 2'b00, "R1 early strobe", int'({tx_change, rx_sample}), 0);
      @(negedge clk);
      // R1/R2: strobe on the second cycle, role chosen by polarity
      chk(tx_change == exp_chg, "R2 tx_change role", int'(tx_change), int'(exp_chg));
      chk(rx_sample == ~exp_chg, "R2 rx_sample role", int'(rx_sample), int'(~exp_chg));
      @(negedge clk);
      chk({tx_change, rx_sample} == 2'b00, "R1 one-cycle strobe", int'({tx_change, rx_sample}), 0);
      if (e == 2 * FRAME_W - 1)
        chk(frame_done == 1'b1, "R5 done pulse", int'(frame_done), 1);
    end
    @(negedge clk);
    chk(frame_done == 1'b0, "R5 done single", int'(frame_done), 0);
    chk(rx_byte == b, inject ? "R8 start ignored" : "R5 rx_byte", int'(rx_byte), int'(b));
    chk(txd == 1'b1, "R4 idle high", int'(txd), 1);
  endtask

  task automatic master_frame(input logic pol, input logic [FRAME_W-1:0] b);
    int since, toggles;
    logic prev, exp_chg;
    bit seen_done;
    master_en = 1'b1; clk_pol = pol;
    repeat (3) @(negedge clk);
    chk(sclk_oe == 1'b1, "R6 oe", int'(sclk_oe), 1);
    chk(sclk_out == pol, "R6 idle level", int'(sclk_out), int'(pol));
    tx_start = 1'b1; tx_byte = b;
    @(negedge clk);
    tx_start = 1'b0;
    since = 0; toggles = 0; prev = sclk_out; seen_done = 1'b0;
    for (int i = 0; i < 200 && !seen_done; i++) begin
      @(negedge clk);
      since++;
      if (sclk_out != prev) begin
        toggles++;
        exp_chg = pol ? prev : ~prev;
        // R6: toggle interval and same-cycle strobe
        chk(since == HALF, "R6 half period", since, HALF);
        chk(tx_change == exp_chg && rx_sample == ~exp_chg, "R6 strobe at toggle",
            int'({tx_change, rx_sample}), int'({exp_chg, ~exp_chg}));
        since = 0;
        prev = sclk_out;
      end
      if (frame_done) seen_done = 1'b1;
    end
    chk(seen_done, "R5 master done", int'(seen_done), 1);
    chk(toggles == 2 * FRAME_W, "R6 toggle count", toggles, 2 * FRAME_W);
    chk(rx_byte == b, "R5 master rx_byte", int'(rx_byte), int'(b));
    repeat (4) @(negedge clk);
    chk(sclk_out == pol, "R6 rest level", int'(sclk_out), int'(pol));
    master_en = 1'b0;
  endtask

  initial begin
    do_reset(1'b1);
    do_reset(1'b0);
    slave_frame(1'b0, 8'hA5, 1'b0);
    slave_frame(1'b1, 8'h3C, 1'b0);
    slave_frame(1'b0, 8'h81, 1'b1);
    slave_frame(1'b1, 8'hFE, 1'b0);
    master_frame(1'b0, 8'h5A);
    master_frame(1'b1, 8'hC3);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule